// File: doc/BRIEF.md
# Reloading Interval Timer with Pin Output

The block is a programmable interval timer for a chip-level peripheral bus. A down-counter is loaded from a preload register when the run bit goes from 0 to 1. It then steps down once every two system clocks. Each time the count has reached zero, the next half-rate tick reloads the counter and sets a sticky status flag. If interrupts are enabled, that flag drives the interrupt line. Software clears the flag by reading the control register.

A three-bit mode field chooses what the timer pin does on each expiry: nothing, a pulse two system clocks wide, or a toggle. An invert bit sets the pin polarity in every mode. When the mode field is zero, the pin can be used instead as a plain software-driven output, steered by a direction bit and a data bit.

The register port has four word addresses, selected by `reg_addr`:
- 0 is the control and status register.
- 1 is the preload register.
- 2 is a read-only copy of the live counter.
- 3 always reads as zero.

Read data is combinational on `reg_addr`. The `reg_rd` strobe only carries the flag-clearing side effect.

Top module: `rldt_top`

## Requirements
- R1: After reset, every readable register is zero, and `pin_oe`, `pin_out` and `irq` are 0.
- R2: The control register holds these fields: run at bit 0, interrupt enable at bit 1, invert at bit 2, mode at bits 5:3, direction at bit 6, status flag at bit 7 and data-out at bit 10. A write that takes run from 0 to 1 loads the counter (address 2) with the preload value (address 1) at that write's clock edge. The counter then decrements on every second clock edge after it, starting with the second.
- R3: On the half-rate tick at which the counter is 0, the counter reloads from preload and the flag (bit 7) sets. With preload N, the first expiry is the clock edge 2N+2 edges after the starting write, and later expiries follow every 2(N+1) edges.
- R4: In mode 001, `pin_oe` is 1. `pin_out` equals the invert bit except during exactly the two clocks that follow each expiry, when it is the opposite level.
- R5: In mode 010, `pin_oe` is 1 and `pin_out` is the invert bit XOR an internal toggle state. That state is cleared when counting starts and flips at every expiry.
- R6: `irq` is high exactly when the flag is set and the interrupt enable bit is 1. Clearing interrupt enable drops `irq` but leaves the flag set.
- R7: A read strobe at address 0 clears the flag, except in a cycle where an expiry also occurs, when the flag stays set. Writes to bit 7 have no effect, and reads at other addresses have no side effect.
- R8: While run is 0, the counter holds its value and the flag never sets.
- R9: Data-out (bit 10) is stored only by a control write whose own mode field is 000 and whose own direction bit is 1. Every other control write leaves it unchanged. In mode 000, `pin_oe` equals the direction bit, and with direction 1 `pin_out` is data-out XOR invert.
- R10: Control bits 8, 9 and 11 to 23 read as zero, and address 3 reads as zero.
- R11: With a preload of 0, the timer expires on every half-rate tick, that is every two clocks.
- R12: Writing run as 1 while the timer is already running does not reload the counter.
- R13: Mode codes 011 and 1xx count and set the flag but drive nothing, so `pin_oe` and `pin_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect only) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, combinational on `reg_addr` |
| pin_out | output | 1 | Timer pin output level |
| pin_oe | output | 1 | Timer pin output enable |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest case to reach from the ports is a flag-clearing read that falls in the same cycle as an expiry. That cycle lasts one clock, and it comes only every 2(N+1) clocks. The stimulus sets the preload to zero so that an expiry falls on every second edge. It then counts edges from the starting write and raises the read strobe exactly on an expiry edge. A second hard spot is stopping the timer in the middle of a count. The stop write is placed on a tick edge, so that the frozen value shows whether that final tick was taken.

// File: rtl/rldt_pkg.sv
// Package: shared field positions, addresses and mode codes for the
// reloading interval timer. Assumes the register data path is at least
// 11 bits wide so that every control field fits.
package rldt_pkg;

    // Control register field positions
    localparam int BIT_RUN  = 0;
    localparam int BIT_IEN  = 1;
    localparam int BIT_INV  = 2;
    localparam int MODE_LO  = 3;
    localparam int MODE_HI  = 5;
    localparam int BIT_DIR  = 6;
    localparam int BIT_FLAG = 7;
    localparam int BIT_DOUT = 10;

    // Register word addresses
    localparam logic [1:0] ADDR_CTRL    = 2'd0;
    localparam logic [1:0] ADDR_PRELOAD = 2'd1;
    localparam logic [1:0] ADDR_COUNT   = 2'd2;
    localparam logic [1:0] ADDR_SPARE   = 2'd3;

    // Pin behaviour codes
    localparam logic [2:0] MODE_QUIET  = 3'b000;
    localparam logic [2:0] MODE_PULSE  = 3'b001;
    localparam logic [2:0] MODE_TOGGLE = 3'b010;

    // Stored control fields
    typedef struct packed {
        logic       run;
        logic       ien;
        logic       inv;
        logic [2:0] mode;
        logic       dir;
    } ctrl_t;

endpackage

// File: rtl/rldt_regs.sv
// Module: register file of the interval timer. It holds the control
// fields, the data-out bit, the sticky status flag and the preload value,
// and it builds the combinational read mux. Assumes DATA_W >= 11 and
// DATA_W >= CNT_W. Read data depends only on reg_addr; reg_rd only clears
// the flag.
module rldt_regs
    import rldt_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CNT_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              expire,
    input  logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] reg_rdata,
    output ctrl_t             ctrl,
    output logic              dout,
    output logic              flag,
    output logic [CNT_W-1:0]  preload,
    output logic              start
);

    ctrl_t            ctrl_q;
    logic             dout_q;
    logic             flag_q;
    logic [CNT_W-1:0] preload_q;
    logic             wr_ctrl;
    logic             wr_pre;
    logic             rd_ctrl;
    logic [2:0]       w_mode;
    logic             gpio_wr;

    // Decode the strobes and the incoming mode for this cycle
    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
        wr_pre  = reg_wr && (reg_addr == ADDR_PRELOAD);
        rd_ctrl = reg_rd && (reg_addr == ADDR_CTRL);
        w_mode  = reg_wdata[MODE_HI:MODE_LO];
        gpio_wr = wr_ctrl && (w_mode == MODE_QUIET) && reg_wdata[BIT_DIR];
        start   = wr_ctrl && reg_wdata[BIT_RUN] && !ctrl_q.run;
    end

    // Control fields: loaded on every control write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.run  <= reg_wdata[BIT_RUN];
            ctrl_q.ien  <= reg_wdata[BIT_IEN];
            ctrl_q.inv  <= reg_wdata[BIT_INV];
            ctrl_q.mode <= w_mode;
            ctrl_q.dir  <= reg_wdata[BIT_DIR];
        end
    end

    // Data-out: stored only when the write itself selects an output in mode 000
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b0;
        end else if (gpio_wr) begin
            dout_q <= reg_wdata[BIT_DOUT];
        end
    end

    // Status flag: expiry sets it and wins over a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end else if (rd_ctrl) begin
            flag_q <= 1'b0;
        end
    end

    // Preload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            preload_q <= '0;
        end else if (wr_pre) begin
            preload_q <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read mux: unused bits and the spare address read as zero
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[BIT_RUN]         = ctrl_q.run;
                reg_rdata[BIT_IEN]         = ctrl_q.ien;
                reg_rdata[BIT_INV]         = ctrl_q.inv;
                reg_rdata[MODE_HI:MODE_LO] = ctrl_q.mode;
                reg_rdata[BIT_DIR]         = ctrl_q.dir;
                reg_rdata[BIT_FLAG]        = flag_q;
                reg_rdata[BIT_DOUT]        = dout_q;
            end
            ADDR_PRELOAD: reg_rdata[CNT_W-1:0] = preload_q;
            ADDR_COUNT:   reg_rdata[CNT_W-1:0] = count;
            default:      reg_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign dout    = dout_q;
    assign flag    = flag_q;
    assign preload = preload_q;

endmodule

// File: rtl/rldt_count.sv
// Module: half-rate prescaler and reloading down-counter. A start pulse
// loads the preload value and resets the phase, so the first tick falls
// two clocks after the start edge. Assumes start is only raised while run
// is low.
module rldt_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             tick,
    output logic             expire
);

    logic             phase_q;
    logic [CNT_W-1:0] count_q;

    // Prescaler phase: advances only while running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else if (start) begin
            phase_q <= 1'b0;
        end else if (run) begin
            phase_q <= ~phase_q;
        end
    end

    // Tick and expiry decode
    always_comb begin
        tick   = run && phase_q;
        expire = tick && (count_q == '0);
    end

    // Counter: load on start, reload on expiry, otherwise step down per tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (start) begin
            count_q <= preload;
        end else if (expire) begin
            count_q <= preload;
        end else if (tick) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign count = count_q;

endmodule

// File: rtl/rldt_pin.sv
// Module: timer pin driver. It produces a fixed-width pulse or a toggle on
// each expiry, or a software-driven level in mode 000, each with an
// optional inversion. Assumes PULSE_LEN >= 1.
module rldt_pin
    import rldt_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       expire,
    input  logic [2:0] mode,
    input  logic       inv,
    input  logic       dir,
    input  logic       dout,
    output logic       pin_out,
    output logic       pin_oe,
    output logic       pulse_act
);

    localparam int PW_W = $clog2(PULSE_LEN + 1);

    logic [PW_W-1:0] pw_q;
    logic            tog_q;

    // Pulse length counter: reloaded at each expiry, runs down to zero
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            pw_q <= '0;
        end else if (expire) begin
            pw_q <= PW_W'(PULSE_LEN);
        end else if (pw_q != '0) begin
            pw_q <= pw_q - 1'b1;
        end
    end

    // Toggle state: cleared on start, flipped at each expiry
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            tog_q <= 1'b0;
        end else if (expire) begin
            tog_q <= ~tog_q;
        end
    end

    assign pulse_act = (pw_q != '0);

    // Pin selection per mode
    always_comb begin
        case (mode)
            MODE_PULSE: begin
                pin_oe  = 1'b1;
                pin_out = pulse_act ^ inv;
            end
            MODE_TOGGLE: begin
                pin_oe  = 1'b1;
                pin_out = tog_q ^ inv;
            end
            MODE_QUIET: begin
                pin_oe  = dir;
                pin_out = dir && (dout ^ inv);
            end
            default: begin
                pin_oe  = 1'b0;
                pin_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rldt_top.sv
// Module: top of the reloading interval timer. It ties the register file,
// the counter and the pin driver together and forms the interrupt line.
// Assumes a single clock domain with a synchronous active-low reset.
module rldt_top
    import rldt_pkg::*;
#(
    parameter int DATA_W    = 24,
    parameter int CNT_W     = 24,
    parameter int PULSE_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);

    ctrl_t            ctrl;
    logic             dout;
    logic             flag;
    logic [CNT_W-1:0] preload;
    logic             start;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             expire;
    logic             pulse_act;

    rldt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .expire    (expire),
        .count     (count),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl),
        .dout      (dout),
        .flag      (flag),
        .preload   (preload),
        .start     (start)
    );

    rldt_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .run     (ctrl.run),
        .preload (preload),
        .count   (count),
        .tick    (tick),
        .expire  (expire)
    );

    rldt_pin #(.PULSE_LEN(PULSE_LEN)) u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .expire    (expire),
        .mode      (ctrl.mode),
        .inv       (ctrl.inv),
        .dir       (ctrl.dir),
        .dout      (dout),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pulse_act (pulse_act)
    );

    // Interrupt: pending flag gated by the enable bit
    assign irq = flag && ctrl.ien;

endmodule

// File: rtl/rldt_checker.sv
// Module: assertion checker for the interval timer, attached to the top
// module by the bind statement at the end of this file.
module rldt_checker
    import rldt_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             ien,
    input logic [2:0]       mode,
    input logic             tick,
    input logic             expire,
    input logic             flag,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] preload,
    input logic             pulse_act,
    input logic             irq
);

    AST_TICK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick); // R2
    AST_RELOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) expire |=> (count == $past(preload))); // R3
    AST_FLAG_FROM_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(expire)); // R3
    AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) $rose(pulse_act) |=> pulse_act); // R4
    AST_PULSE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n) (expire && (mode == MODE_PULSE)) |=> pulse_act); // R4
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(expire) || $rose(ien))); // R6
    AST_FROZEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run && !$past(run)) |-> $stable(count)); // R8
    AST_NO_FLAG_STOPPED: assert property (@(posedge clk) disable iff (!rst_n) (!run && !$past(run)) |-> !$rose(flag)); // R8

endmodule

bind rldt_top rldt_checker #(.CNT_W(CNT_W)) u_rldt_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (ctrl.run),
    .ien       (ctrl.ien),
    .mode      (ctrl.mode),
    .tick      (tick),
    .expire    (expire),
    .flag      (flag),
    .count     (count),
    .preload   (preload),
    .pulse_act (pulse_act),
    .irq       (irq)
);

// File: tb/test_rldt_top.sv
// Bench: directed scenarios, one task each. All inputs change at the
// falling edge and outputs are sampled there, so "after edge En" means
// the falling edge that follows rising edge En.
module test_rldt_top;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 24;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_PRE  = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;
    localparam logic [1:0] A_SPR  = 2'd3;

    localparam logic [23:0] C_RUN  = 24'h000001;
    localparam logic [23:0] C_IEN  = 24'h000002;
    localparam logic [23:0] C_INV  = 24'h000004;
    localparam logic [23:0] C_PUL  = 24'h000008;
    localparam logic [23:0] C_TOG  = 24'h000010;
    localparam logic [23:0] C_DIR  = 24'h000040;
    localparam logic [23:0] C_DOUT = 24'h000400;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [1:0]        reg_addr = 2'd0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              pin_out;
    logic              pin_oe;
    logic              irq;

    int  checks = 0;
    int  errors = 0;
    bit  reported = 1'b0;

    rldt_top i_rldt_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [23:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [23:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic rd_ctrl(output logic [23:0] v);
        reg_rd = 1'b1; reg_addr = A_CTRL;
        #1;
        v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic quiesce();
        logic [23:0] v;
        wr(A_CTRL, 24'h0);
        rd_ctrl(v);
    endtask

    task automatic t_reset();
        logic [23:0] v;
        peek(A_CTRL, v); chk("R1", "ctrl after reset", 32'(v), 0);
        peek(A_PRE, v);  chk("R1", "preload after reset", 32'(v), 0);
        peek(A_CNT, v);  chk("R1", "count after reset", 32'(v), 0);
        chk("R1", "pin_oe after reset", 32'(pin_oe), 0);
        chk("R1", "pin_out after reset", 32'(pin_out), 0);
        chk("R1", "irq after reset", 32'(irq), 0);
    endtask

    task automatic t_count();
        logic [23:0] v;
        quiesce();
        wr(A_PRE, 24'd3);
        wr(A_CTRL, C_RUN | C_IEN);                          // E0
        peek(A_CNT, v); chk("R2", "count loaded at E0", 32'(v), 3);
        step(1); peek(A_CNT, v); chk("R2", "count after E1", 32'(v), 3);
        step(1); peek(A_CNT, v); chk("R2", "count after E2", 32'(v), 2);
        step(4); peek(A_CNT, v); chk("R2", "count after E6", 32'(v), 0);
        step(1); chk("R3", "irq before expiry E7", 32'(irq), 0);
        step(1); chk("R3", "irq at expiry E8", 32'(irq), 1);
        peek(A_CNT, v); chk("R3", "count reloaded at E8", 32'(v), 3);
        rd_ctrl(v); chk("R7", "flag bit read", 32'(v[7]), 1);   // clears at E9
        chk("R7", "irq after clearing read", 32'(irq), 0);
        step(6); chk("R3", "irq after E15", 32'(irq), 0);
        step(1); chk("R3", "irq at second expiry E16", 32'(irq), 1);
        wr(A_CTRL, C_RUN);                                   // drop ien
        chk("R6", "irq with ien cleared", 32'(irq), 0);
        peek(A_CTRL, v); chk("R6", "flag kept with ien cleared", 32'(v[7]), 1);
        wr(A_CTRL, C_RUN | C_IEN);
        chk("R6", "irq after ien restored", 32'(irq), 1);
    endtask

    task automatic t_freeze();
        logic [23:0] v;
        quiesce();
        wr(A_PRE, 24'd5);
        wr(A_CTRL, C_RUN | C_IEN);                           // E0
        step(5); peek(A_CNT, v); chk("R2", "count after E5", 32'(v), 3);
        wr(A_CTRL, C_IEN);                                   // stop at E6, tick taken
        peek(A_CNT, v); chk("R8", "count at stop", 32'(v), 2);
        step(20); peek(A_CNT, v); chk("R8", "count frozen", 32'(v), 2);
        chk("R8", "no irq while stopped", 32'(irq), 0);
        wr(A_CTRL, C_RUN | C_IEN);
        peek(A_CNT, v); chk("R2", "restart reloads", 32'(v), 5);
    endtask

    task automatic t_rerun();
        logic [23:0] v;
        quiesce();
        wr(A_PRE, 24'd5);
        wr(A_CTRL, C_RUN);                                   // E0
        step(5); peek(A_CNT, v); chk("R12", "count after E5", 32'(v), 3);
        wr(A_CTRL, C_RUN | C_IEN);                           // E6
        peek(A_CNT, v); chk("R12", "no reload on rewrite", 32'(v), 2);
    endtask

    task automatic t_pulse();
        quiesce();
        wr(A_PRE, 24'd2);
        wr(A_CTRL, C_RUN | C_PUL);                           // E0, expiry at E6
        chk("R4", "pin_oe in pulse mode", 32'(pin_oe), 1);
        step(5); chk("R4", "pin idle after E5", 32'(pin_out), 0);
        step(1); chk("R4", "pulse after E6", 32'(pin_out), 1);
        step(1); chk("R4", "pulse after E7", 32'(pin_out), 1);
        step(1); chk("R4", "pulse ends after E8", 32'(pin_out), 0);
        step(4); chk("R4", "second pulse after E12", 32'(pin_out), 1);
        quiesce();
        wr(A_CTRL, C_RUN | C_PUL | C_INV);
        step(5); chk("R4", "inverted idle after E5", 32'(pin_out), 1);
        step(1); chk("R4", "inverted pulse after E6", 32'(pin_out), 0);
        step(1); chk("R4", "inverted pulse after E7", 32'(pin_out), 0);
        step(1); chk("R4", "inverted pulse ends after E8", 32'(pin_out), 1);
    endtask

    task automatic t_toggle();
        quiesce();
        wr(A_PRE, 24'd1);
        wr(A_CTRL, C_RUN | C_TOG);                           // expiries at E4, E8
        chk("R5", "pin_oe in toggle mode", 32'(pin_oe), 1);
        chk("R5", "toggle start level", 32'(pin_out), 0);
        step(3); chk("R5", "toggle after E3", 32'(pin_out), 0);
        step(1); chk("R5", "toggle after E4", 32'(pin_out), 1);
        step(3); chk("R5", "toggle after E7", 32'(pin_out), 1);
        step(1); chk("R5", "toggle after E8", 32'(pin_out), 0);
        quiesce();
        wr(A_CTRL, C_RUN | C_TOG | C_INV);
        chk("R5", "inverted toggle start", 32'(pin_out), 1);
        step(4); chk("R5", "inverted toggle after E4", 32'(pin_out), 0);
    endtask

    task automatic t_gpio();
        logic [23:0] v;
        quiesce();
        wr(A_CTRL, C_DIR | C_DOUT);
        chk("R9", "gpio oe", 32'(pin_oe), 1);
        chk("R9", "gpio drives 1", 32'(pin_out), 1);
        peek(A_CTRL, v); chk("R9", "dout stored", 32'(v[10]), 1);
        wr(A_CTRL, C_DIR | C_DOUT | C_INV);
        chk("R9", "gpio inverted", 32'(pin_out), 0);
        wr(A_CTRL, C_DIR | C_INV);
        chk("R9", "gpio dout 0 inverted", 32'(pin_out), 1);
        wr(A_CTRL, C_PUL | C_DOUT);
        peek(A_CTRL, v); chk("R9", "dout ignored in mode 001", 32'(v[10]), 0);
        wr(A_CTRL, C_TOG | C_DIR | C_DOUT);
        peek(A_CTRL, v); chk("R9", "dout ignored in mode 010", 32'(v[10]), 0);
        wr(A_CTRL, C_DOUT);
        peek(A_CTRL, v); chk("R9", "dout ignored with dir 0", 32'(v[10]), 0);
        chk("R9", "oe off with dir 0", 32'(pin_oe), 0);
        chk("R9", "pin low with dir 0", 32'(pin_out), 0);
    endtask

    task automatic t_reserved();
        logic [23:0] v;
        quiesce();
        wr(A_PRE, 24'd1000);
        wr(A_CTRL, 24'hFFFFFF);
        peek(A_CTRL, v);
        chk("R10", "ctrl bits 23:11", 32'(v[23:11]), 0);
        chk("R10", "ctrl bits 9:8", 32'(v[9:8]), 0);
        chk("R7", "flag not writable", 32'(v[7]), 0);
        chk("R13", "mode 111 oe off", 32'(pin_oe), 0);
        chk("R13", "mode 111 pin low", 32'(pin_out), 0);
        peek(A_SPR, v); chk("R10", "spare address", 32'(v), 0);
        peek(A_PRE, v); chk("R10", "preload readback", 32'(v), 1000);
    endtask

    task automatic t_odd_mode();
        logic [23:0] v;
        quiesce();
        wr(A_PRE, 24'd0);
        wr(A_CTRL, C_RUN | C_PUL | C_TOG | C_INV | C_DIR);    // mode 011, expiry at E2
        step(2); peek(A_CTRL, v); chk("R13", "mode 011 sets flag", 32'(v[7]), 1);
        chk("R13", "mode 011 oe off", 32'(pin_oe), 0);
        chk("R13", "mode 011 pin low", 32'(pin_out), 0);
    endtask

    task automatic t_zero();
        logic [23:0] v;
        quiesce();
        wr(A_PRE, 24'd0);
        wr(A_CTRL, C_RUN | C_IEN);                           // E0
        step(1); chk("R11", "irq after E1", 32'(irq), 0);
        step(1); chk("R11", "irq after E2", 32'(irq), 1);
        rd_ctrl(v);                                          // clears at E3
        chk("R11", "irq cleared after E3", 32'(irq), 0);
        step(1); chk("R11", "irq again after E4", 32'(irq), 1);
        step(1);
        rd_ctrl(v);                                          // read on expiry edge E6
        chk("R7", "expiry beats clearing read", 32'(irq), 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_freeze();
        t_rerun();
        t_pulse();
        t_toggle();
        t_gpio();
        t_reserved();
        t_odd_mode();
        t_zero();
        quiesce();
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
        $finish;
    end

endmodule